// File: doc/BRIEF.md
# Flash Directory Signature Scanner

This block locates a directory header inside a byte-addressed parallel flash and pulls one entry out of it. After a start pulse it walks candidate offsets from zero upward in fixed strides. At each candidate it reads bytes one at a time and compares them with a 32-byte signature held in a parameter. It leaves a candidate at the first byte that differs. When all 32 bytes agree, the candidate offset becomes the directory offset. The block then reads the little-endian revision word that follows the signature.

With a supported revision, it scans a fixed table of 32 entries of 64 bytes each. The table starts at a parameterised distance from the header. Each entry's type word has its two top bits cleared before it is compared with the requested type. For the first entry that matches, the block returns the entry's 32-bit offset field and padded-size field.

All flash traffic goes through a single byte read port with a wait handshake. The outcome is held on the outputs until the next start.

Top module: `flash_dir_scan`

## Requirements
- R1: Candidate offsets are visited in the order 0, STRIDE, 2*STRIDE, ... while below LIMIT (defaults 0x2000 and 0x200000). The lowest matching candidate wins, and its offset appears on `dir_offs`.
- R2: A candidate matches only if flash bytes cand+0 to cand+31 equal signature bytes 0 to 31. Signature byte 0 is the leftmost character of `SIG`. The compare reads bytes in ascending order and stops after the first unequal byte.
- R3: If no candidate matches, `done` rises with `found` = 0 and `status` = 1 (no directory).
- R4: The revision is the little-endian word at bytes cand+32 to cand+35. Any value other than 2 ends the search with `found` = 1, `status` = 2 and the value on `dir_rev`.
- R5: Entry k has its base at cand+ENT_BASE+64*k, and its type word is the little-endian word at the entry base. The type word, ANDed with 0x3FFFFFFF, is compared with `req_type` for k = 0 to 31 in order. The first equal entry is selected.
- R6: For the selected entry, `ent_offs` is the little-endian word at entry+4 and `ent_size` is the little-endian word at entry+8. In this case `status` = 0 and `found` = 1.
- R7: If none of the 32 entries matches, `status` = 3 with `found` = 1.
- R8: A byte is taken only in a cycle where `mem_req` = 1 and `mem_wait` = 0. While `mem_wait` holds a request, `mem_req` and `mem_addr` stay unchanged.
- R9: After `done`, all results stay stable and `mem_req` stays low until the next `start`. A `start` during a search has no effect.
- R10: After reset, `done`, `found` and `mem_req` are 0 and `status` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a search when idle or finished |
| req_type | input | 30 | Entry type to look for |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | ADDR_W | Byte address of the request |
| mem_wait | input | 1 | Flash not ready; request must be held |
| mem_rdata | input | 8 | Read byte, valid when request is high and wait is low |
| done | output | 1 | Search finished; held until next start |
| found | output | 1 | Signature located |
| status | output | 2 | 0 ok, 1 no directory, 2 bad revision, 3 no entry |
| dir_offs | output | ADDR_W | Offset of the matching header |
| dir_rev | output | 32 | Revision word read from the header |
| ent_offs | output | 32 | Offset field of the selected entry |
| ent_size | output | 32 | Padded-size field of the selected entry |

## Verification
The assertions assume the flash side returns a byte whenever `mem_wait` is low during a request. They also assume `mem_rdata` is stable from the falling edge up to the sampling edge. The stimulus drives `mem_wait` and `mem_rdata` only on falling edges from a behavioural byte store, with `mem_wait` taken from a pseudo-random sequence or tied low.

Each accepted read address is compared with a queue produced by a behavioural model of the search. Any restart or stray read therefore shows at once. The layouts placed in the store exercise:
- partial-signature decoys
- two headers, where the first one wins
- a header at the last stride
- an unsupported revision
- a type that matches only after masking
- a missing type

// File: rtl/fds_pkg.sv
package fds_pkg;

  typedef enum logic [1:0] {
    FDS_OK       = 2'd0,
    FDS_NO_DIR   = 2'd1,
    FDS_BAD_REV  = 2'd2,
    FDS_NO_ENTRY = 2'd3
  } fds_status_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SIG, PH_REV, PH_TYPE, PH_OFFS, PH_SIZE, PH_DONE
  } fds_phase_e;

  // Byte i of a 32-character pattern, leftmost character first.
  function automatic logic [7:0] sig_byte(input logic [255:0] pat, input logic [4:0] i);
    logic [255:0] t;
    t = pat << {i, 3'b000};
    return t[255:248];
  endfunction

  // Type key with the two top flag bits removed.
  function automatic logic [29:0] type_key(input logic [31:0] w);
    logic [31:0] m;
    m = w & 32'h3FFF_FFFF;
    return m[29:0];
  endfunction

  // Drop a byte into a little-endian word at lane pos.
  function automatic logic [31:0] merge_le(input logic [31:0] acc, input logic [1:0] pos,
                                           input logic [7:0] b);
    logic [31:0] r;
    r = acc;
    r[8*pos +: 8] = b;
    return r;
  endfunction

  function automatic logic [31:0] entry_base(input logic [31:0] cand, input logic [31:0] first,
                                             input logic [31:0] k, input logic [31:0] bytes);
    return cand + first + k * bytes;
  endfunction

endpackage

// File: rtl/fds_fetch.sv
module fds_fetch
  import fds_pkg::*;
#(
  parameter int ADDR_W = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        nbytes,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_wait,
  input  logic [7:0]        mem_rdata,
  output logic              ready,
  output logic [31:0]       word
);
  logic              active;
  logic [ADDR_W-1:0] base;
  logic [1:0]        cnt, last;
  logic [31:0]       acc;
  logic              take;
  logic [31:0]       acc_nxt;

  assign mem_req  = active;
  assign mem_addr = base + ADDR_W'(cnt);
  assign take     = active && !mem_wait;
  assign acc_nxt  = merge_le(acc, cnt, mem_rdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      base   <= '0;
      cnt    <= '0;
      last   <= '0;
      acc    <= '0;
      ready  <= 1'b0;
      word   <= '0;
    end else begin
      ready <= 1'b0;
      if (go && !active) begin
        active <= 1'b1;
        base   <= addr;
        cnt    <= '0;
        last   <= 2'(nbytes - 3'd1);
        acc    <= '0;
      end else if (take) begin
        acc <= acc_nxt;
        if (cnt == last) begin
          active <= 1'b0;
          ready  <= 1'b1;
          word   <= acc_nxt;
        end else begin
          cnt <= cnt + 2'd1;
        end
      end
    end
  end

  // R8: a held request keeps its address
  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_wait |=> mem_req && $stable(mem_addr));

endmodule

// File: rtl/fds_sig_match.sv
module fds_sig_match
  import fds_pkg::*;
#(
  parameter logic [255:0] SIG = "#FLASH#DIRECTORY#HEADER#MARK#V2#"
) (
  input  logic [4:0] idx,
  input  logic [7:0] rbyte,
  output logic       hit,
  output logic       final_byte
);
  assign hit        = (rbyte == sig_byte(SIG, idx));
  assign final_byte = (idx == 5'd31);
endmodule

// File: rtl/flash_dir_scan.sv
module flash_dir_scan
  import fds_pkg::*;
#(
  parameter int            ADDR_W    = 21,
  parameter logic [31:0]   STRIDE    = 32'h0000_2000,
  parameter logic [31:0]   LIMIT     = 32'h0020_0000,
  parameter logic [255:0]  SIG       = "#FLASH#DIRECTORY#HEADER#MARK#V2#",
  parameter logic [31:0]   REV_OFFS  = 32'd32,
  parameter logic [31:0]   ENT_BASE  = 32'h0000_0090,
  parameter int            NUM_ENT   = 32,
  parameter logic [31:0]   ENT_BYTES = 32'd64,
  parameter logic [31:0]   REV_OK    = 32'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [29:0]       req_type,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_wait,
  input  logic [7:0]        mem_rdata,
  output logic              done,
  output logic              found,
  output logic [1:0]        status,
  output logic [ADDR_W-1:0] dir_offs,
  output logic [31:0]       dir_rev,
  output logic [31:0]       ent_offs,
  output logic [31:0]       ent_size
);
  localparam int ENT_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;

  fds_phase_e        phase;
  logic              pend;
  logic [ADDR_W-1:0] cand;
  logic [4:0]        idx;
  logic [ENT_W-1:0]  ent;

  // Named internal events
  logic              go, fw_ready;
  logic [31:0]       fw_word;
  logic [ADDR_W-1:0] f_addr;
  logic [2:0]        f_len;
  logic              sig_hit, sig_final, cand_last, type_hit, ent_last, launch;
  logic [31:0]       ent_at;

  assign launch    = start && (phase == PH_IDLE || phase == PH_DONE);
  assign cand_last = (32'(cand) + STRIDE) >= LIMIT;
  assign type_hit  = (type_key(fw_word) == req_type);
  assign ent_last  = (32'(ent) == NUM_ENT - 1);
  assign ent_at    = entry_base(32'(cand), ENT_BASE, 32'(ent), ENT_BYTES);

  always_comb begin
    f_addr = cand + ADDR_W'(idx);
    f_len  = 3'd1;
    case (phase)
      PH_REV:  begin f_addr = ADDR_W'(32'(cand) + REV_OFFS); f_len = 3'd4; end
      PH_TYPE: begin f_addr = ADDR_W'(ent_at);               f_len = 3'd4; end
      PH_OFFS: begin f_addr = ADDR_W'(ent_at + 32'd4);       f_len = 3'd4; end
      PH_SIZE: begin f_addr = ADDR_W'(ent_at + 32'd8);       f_len = 3'd4; end
      default: ;
    endcase
  end

  assign go = !pend && (phase == PH_SIG || phase == PH_REV || phase == PH_TYPE ||
                        phase == PH_OFFS || phase == PH_SIZE);

  fds_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .go(go), .addr(f_addr), .nbytes(f_len),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_wait(mem_wait),
    .mem_rdata(mem_rdata), .ready(fw_ready), .word(fw_word)
  );

  fds_sig_match #(.SIG(SIG)) u_sig (
    .idx(idx), .rbyte(fw_word[7:0]), .hit(sig_hit), .final_byte(sig_final)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE; pend <= 1'b0; cand <= '0; idx <= '0; ent <= '0;
      done <= 1'b0; found <= 1'b0; status <= FDS_OK; dir_offs <= '0;
      dir_rev <= '0; ent_offs <= '0; ent_size <= '0;
    end else if (launch) begin
      phase <= PH_SIG; pend <= 1'b0; cand <= '0; idx <= '0; ent <= '0;
      done <= 1'b0; found <= 1'b0; status <= FDS_OK; dir_offs <= '0;
      dir_rev <= '0; ent_offs <= '0; ent_size <= '0;
    end else begin
      if (go) pend <= 1'b1;
      if (fw_ready) begin
        pend <= 1'b0;
        case (phase)
          PH_SIG: begin
            if (sig_hit && sig_final) begin
              found <= 1'b1; dir_offs <= cand; phase <= PH_REV;
            end else if (sig_hit) begin
              idx <= idx + 5'd1;
            end else begin
              idx <= '0;
              if (cand_last) begin
                status <= FDS_NO_DIR; done <= 1'b1; phase <= PH_DONE;
              end else begin
                cand <= ADDR_W'(32'(cand) + STRIDE);
              end
            end
          end
          PH_REV: begin
            dir_rev <= fw_word;
            if (fw_word != REV_OK) begin
              status <= FDS_BAD_REV; done <= 1'b1; phase <= PH_DONE;
            end else begin
              ent <= '0; phase <= PH_TYPE;
            end
          end
          PH_TYPE: begin
            if (type_hit)      phase <= PH_OFFS;
            else if (ent_last) begin
              status <= FDS_NO_ENTRY; done <= 1'b1; phase <= PH_DONE;
            end else           ent <= ent + ENT_W'(1);
          end
          PH_OFFS: begin ent_offs <= fw_word; phase <= PH_SIZE; end
          PH_SIZE: begin
            ent_size <= fw_word; status <= FDS_OK; done <= 1'b1; phase <= PH_DONE;
          end
          default: ;
        endcase
      end
    end
  end

  // R3: no directory means found stays low
  assert_nodir_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done && status == FDS_NO_DIR |-> !found);
  // R4: a clean finish carries the supported revision
  assert_ok_rev_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done && status == FDS_OK |-> found && dir_rev == REV_OK);
  // R1: a found header lies on a stride boundary below the limit
  assert_stride_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done && found |-> (32'(dir_offs) % STRIDE) == 0 && 32'(dir_offs) < LIMIT);
  // R9: results frozen until restart
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(status) && $stable(found) && $stable(dir_offs)
                       && $stable(ent_offs) && $stable(ent_size) && $stable(dir_rev));
  // R9: no flash traffic after completion
  assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);

endmodule

// File: tb/sim_flash_dir_scan.sv
module sim_flash_dir_scan;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 21;
  localparam int STRIDE = 'h2000;
  localparam int LIMIT  = 'h200000;
  localparam logic [255:0] B_SIG = "#FLASH#DIRECTORY#HEADER#MARK#V2#";

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [29:0] req_type = '0;
  logic mem_req, mem_wait = 1'b0;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] mem_rdata = 8'hFF;
  logic done, found;
  logic [1:0] status;
  logic [ADDR_W-1:0] dir_offs;
  logic [31:0] dir_rev, ent_offs, ent_size;

  int checks = 0, errors = 0, cyc = 0;
  logic wait_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0] fl [int];
  int exp_q[$];
  logic e_found; int e_st, e_dir; logic [31:0] e_rev, e_offs, e_size;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_dir_scan u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .req_type(req_type),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_wait(mem_wait), .mem_rdata(mem_rdata),
    .done(done), .found(found), .status(status), .dir_offs(dir_offs),
    .dir_rev(dir_rev), .ent_offs(ent_offs), .ent_size(ent_size)
  );

  function automatic logic [7:0] rd(input int a);
    return fl.exists(a) ? fl[a] : 8'hFF;
  endfunction
  function automatic logic [31:0] rd4(input int a);
    return {rd(a+3), rd(a+2), rd(a+1), rd(a)};
  endfunction
  function automatic logic [7:0] sb(input int k);
    logic [255:0] s;
    s = B_SIG >> (8 * (31 - k));
    return s[7:0];
  endfunction

  task automatic check(input string req, input logic ok, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic put32(input int a, input logic [31:0] v);
    for (int i = 0; i < 4; i++) fl[a+i] = v[8*i +: 8];
  endtask
  task automatic put_sig(input int base, input int good);
    for (int i = 0; i < good; i++) fl[base+i] = sb(i);
    if (good < 32) fl[base+good] = sb(good) ^ 8'h01;
  endtask
  task automatic put_ent(input int dir, input int k, input logic [31:0] t,
                         input logic [31:0] o, input logic [31:0] s);
    put32(dir + 'h90 + 64*k, t); put32(dir + 'h90 + 64*k + 4, o); put32(dir + 'h90 + 64*k + 8, s);
  endtask

  // Behavioural model: expected read addresses and results
  task automatic model(input logic [29:0] rt);
    int c, k;
    exp_q.delete(); e_found = 0; e_st = 1; e_dir = 0; e_rev = 0; e_offs = 0; e_size = 0;
    for (c = 0; c < LIMIT; c += STRIDE) begin
      for (k = 0; k < 32; k++) begin
        exp_q.push_back(c + k);
        if (rd(c + k) != sb(k)) break;
      end
      if (k == 32) begin e_found = 1; e_dir = c; break; end
    end
    if (e_found) begin
      for (int i = 0; i < 4; i++) exp_q.push_back(e_dir + 32 + i);
      e_rev = rd4(e_dir + 32);
      if (e_rev != 2) e_st = 2;
      else begin
        e_st = 3;
        for (int e = 0; e < 32; e++) begin
          int a;
          a = e_dir + 'h90 + 64 * e;
          for (int i = 0; i < 4; i++) exp_q.push_back(a + i);
          if ((rd4(a) & 32'h3FFFFFFF) == {2'b00, rt}) begin
            for (int i = 4; i < 12; i++) exp_q.push_back(a + i);
            e_offs = rd4(a + 4); e_size = rd4(a + 8); e_st = 0;
            break;
          end
        end
      end
    end
  endtask

  // Flash side and per-clock comparison against the model queue
  always @(negedge clk) begin
    cyc++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_wait = wait_en & lfsr[0];
    mem_rdata = rd(int'(mem_addr));
    if (rst_n && mem_req && !mem_wait) begin
      if (exp_q.size() == 0) check("R8 stray read", 1'b0, mem_addr, 0);
      else begin
        int ea;
        ea = exp_q.pop_front();
        check("R1/R2/R5 read address", int'(mem_addr) == ea, mem_addr, ea);
      end
    end
    if (cyc > 190000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run(input string tag, input logic [29:0] rt, input bit mid_start);
    model(rt);
    req_type = rt;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (mid_start) begin
      repeat (12) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    while (!done) @(negedge clk);
    check({tag, " found"}, found == e_found, found, e_found);
    check({tag, " status"}, int'(status) == e_st, status, e_st);
    if (e_found) check({tag, " dir_offs R1"}, int'(dir_offs) == e_dir, dir_offs, e_dir);
    if (e_found) check({tag, " dir_rev R4"}, dir_rev == e_rev, dir_rev, e_rev);
    if (e_st == 0) begin
      check({tag, " ent_offs R6"}, ent_offs == e_offs, ent_offs, e_offs);
      check({tag, " ent_size R6"}, ent_size == e_size, ent_size, e_size);
    end
    check({tag, " all reads done R2"}, exp_q.size() == 0, exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 done", done == 1'b0, done, 0);
    check("R10 found", found == 1'b0, found, 0);
    check("R10 mem_req", mem_req == 1'b0, mem_req, 0);
    check("R10 status", status == 2'd0, status, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: empty flash, no header anywhere
    wait_en = 1'b1;
    run("R3 empty", 30'h120, 1'b0);

    // R2 R5: decoys then header with masked-type match
    fl.delete();
    put_sig('h0000, 5); put_sig('h2000, 31); put_sig('h6000, 32); put32('h6000 + 32, 2);
    put_ent('h6000, 0, 32'h0000_0121, 32'h1, 32'h2);
    put_ent('h6000, 1, 32'hC000_0120, 32'h0001_0000, 32'h0000_4000);
    put_ent('h6000, 5, 32'h0000_0120, 32'h0BAD_0000, 32'h0BAD_0001);
    run("R5 masked first match", 30'h120, 1'b0);

    // R4 R1: first of two headers wins, unsupported revision
    fl.delete();
    put_sig('h4000, 32); put32('h4000 + 32, 3);
    put_sig('h8000, 32); put32('h8000 + 32, 2); put_ent('h8000, 0, 32'h120, 32'h5, 32'h6);
    run("R4 bad revision", 30'h120, 1'b0);

    // R7: header at last stride, type absent
    fl.delete();
    put_sig('h1FE000, 32); put32('h1FE000 + 32, 2);
    put_ent('h1FE000, 3, 32'h0000_0120, 32'h7, 32'h8);
    run("R7 no entry", 30'h0E0, 1'b0);

    // R6 R9: match in the final entry, stray start mid-search, no wait
    put_ent('h1FE000, 31, 32'h4000_00E0, 32'h0012_3400, 32'h0000_ABCD);
    wait_en = 1'b0;
    run("R6 last entry", 30'h0E0, 1'b1);

    // R9: results held after done while inputs move
    req_type = 30'h3;
    repeat (20) @(negedge clk);
    check("R9 done held", done == 1'b1, done, 1);
    check("R9 ent_offs held", ent_offs == 32'h0012_3400, ent_offs, 32'h0012_3400);
    check("R9 ent_size held", ent_size == 32'h0000_ABCD, ent_size, 32'h0000_ABCD);
    check("R9 no request", mem_req == 1'b0, mem_req, 0);

    // R8: waits on again, restart finds same entry
    wait_en = 1'b1;
    run("R8 rerun with wait", 30'h0E0, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule